// File: doc/BRIEF.md
# Phased-Write Pseudo Dual-Port Memory

This block presents one read port and one write port on top of two single-port RAM banks, each of which can do only one read or one write per cycle. Writes are taken on alternate cycles only: a parameter fixes whether the write slot falls on the even or the odd phase counted from reset. A read may be issued on every cycle and returns its data one cycle later.

In a write slot the primary bank (bank 0) takes the write while the mirror bank (bank 1) serves the read. On the cycle after, the same address and data come out of a holding register into the mirror bank while the primary bank serves the read, so the two banks hold identical contents again. A parameter selects whether a read that hits the address being written in the same cycle returns the new data (transparent) or the old data. A combinational debug port reads either bank directly, with no clock delay.

The write source uses the `wr_slot` output to time its writes; a write presented outside the slot is dropped.

Top module: `phased_pdp_sram`

## Requirements
- R1: Out of reset the first cycle is phase 0; `wr_slot` is high in phase 0 when `WR_ODD`=0 and in phase 1 when `WR_ODD`=1, and it inverts on every clock.
- R2: A write with `wr_en` high while `wr_slot` is high stores `wr_data` at `wr_addr`; any read of that address issued in a later cycle returns it.
- R3: A write with `wr_en` high while `wr_slot` is low changes neither bank, seen on reads and on the debug port.
- R4: The address on `rd_addr` is sampled on every clock edge and its data appears on `rd_data` after that edge, for the whole following cycle.
- R5: With `TRANSPARENT`=0, a read issued in the same cycle as an accepted write to the same address returns the contents from before the write.
- R6: With `TRANSPARENT`=1, a read issued in the same cycle as an accepted write to the same address returns the data being written.
- R7: The mirror bank receives the accepted write on the clock edge after the primary bank does; no cycle writes both banks, and the two banks agree at that address afterwards.
- R8: `dbg_data` combinationally shows the word at `dbg_addr` in the bank chosen by `dbg_sel` (0 = primary, 1 = mirror).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of the phase and steering state |
| wr_slot | output | 1 | High in the cycles where a write is accepted |
| wr_en | input | 1 | Write request |
| wr_addr | input | AW | Write address |
| wr_data | input | DW | Write data |
| rd_addr | input | AW | Read address, sampled every cycle |
| rd_data | output | DW | Read data, one cycle after the address |
| dbg_sel | input | 1 | Debug bank select: 0 primary, 1 mirror |
| dbg_addr | input | AW | Debug read address |
| dbg_data | output | DW | Combinational debug read data |

## Verification
The hard case is the window between the two halves of a write, when the primary bank already holds a new word and the mirror bank does not, combined with a read or a debug access at that address. The stimulus keeps the address space small and forces the read address onto the write address in a large share of cycles, so collisions land in write slots, in copy cycles and outside the slot. Two instances with opposite phase and transparency settings run on the same stimulus, so every write request is legal for one and dropped by the other, and both collision modes are compared against the behavioural model.

// File: rtl/phased_pdp_sram.sv
module phased_pdp_sram #(
  parameter int AW          = 4,
  parameter int DW          = 16,
  parameter bit WR_ODD      = 1'b0,
  parameter bit TRANSPARENT = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic          wr_slot,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  input  logic          dbg_sel,
  input  logic [AW-1:0] dbg_addr,
  output logic [DW-1:0] dbg_data
);
  localparam int DEPTH = 1 << AW;

  logic          phase;
  logic          take;
  logic          pend;
  logic [AW-1:0] hold_addr;
  logic [DW-1:0] hold_data;
  logic          from_pri;

  logic [DW-1:0] pri_mem [DEPTH];
  logic [DW-1:0] mir_mem [DEPTH];
  logic          pri_we, mir_we;
  logic [AW-1:0] pri_a, mir_a;
  logic [DW-1:0] pri_d, mir_d;
  logic [DW-1:0] pri_q, mir_q;

  assign wr_slot = (phase == WR_ODD);
  assign take    = wr_slot & wr_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= 1'b0;
      pend  <= 1'b0;
    end else begin
      phase <= ~phase;
      pend  <= take;
    end
  end

  always_ff @(posedge clk) begin
    if (take) begin
      hold_addr <= wr_addr;
      hold_data <= wr_data;
    end
  end

  assign pri_we = take;
  assign pri_a  = wr_slot ? wr_addr : rd_addr;
  assign pri_d  = wr_data;
  assign mir_we = ~wr_slot & pend;
  assign mir_a  = wr_slot ? rd_addr : hold_addr;
  assign mir_d  = hold_data;

  always_ff @(posedge clk) begin
    if (pri_we) begin
      pri_mem[pri_a] <= pri_d;
      pri_q          <= pri_d;
    end else begin
      pri_q <= pri_mem[pri_a];
    end
  end

  always_ff @(posedge clk) begin
    if (mir_we) begin
      mir_mem[mir_a] <= mir_d;
      mir_q          <= mir_d;
    end else begin
      mir_q <= mir_mem[mir_a];
    end
  end

  generate
    if (TRANSPARENT) begin : g_bypass
      always_ff @(posedge clk) begin
        if (!rst_n) from_pri <= 1'b0;
        else        from_pri <= ~wr_slot | (take & (rd_addr == wr_addr));
      end
    end else begin : g_plain
      always_ff @(posedge clk) begin
        if (!rst_n) from_pri <= 1'b0;
        else        from_pri <= ~wr_slot;
      end
    end
  endgenerate

  assign rd_data  = from_pri ? pri_q : mir_q;
  assign dbg_data = dbg_sel ? mir_mem[dbg_addr] : pri_mem[dbg_addr];

  // R1
  slot_alt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_slot |=> !wr_slot);

  // R3
  off_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_slot |-> !pri_we);

  // R7
  one_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(pri_we && mir_we));

  // R7
  copy_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (mir_we && mir_a == $past(wr_addr) && mir_d == $past(wr_data)));

  // R7
  mirror_eq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mir_we |=> (pri_mem[$past(mir_a)] == mir_mem[$past(mir_a)]));

  generate
    if (TRANSPARENT) begin : g_chk_t
      // R6
      bypass_new_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && rd_addr == wr_addr) |=> rd_data == $past(wr_data));
    end else begin : g_chk_nt
      // R5
      collide_old_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && rd_addr == wr_addr) |=> rd_data == $past(mir_mem[rd_addr]));
    end
  endgenerate
endmodule

// File: tb/tb_phased_pdp_sram.sv
module tb_phased_pdp_sram;
  localparam int AW = 4;
  localparam int DW = 16;
  localparam int DEPTH = 1 << AW;
  localparam int NCYC = 3000;
  localparam int INIT = 32;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst_n;
  logic          wr_en;
  logic [AW-1:0] wr_addr, rd_addr, dbg_addr;
  logic [DW-1:0] wr_data;
  logic          dbg_sel;
  logic          slot [2];
  logic [DW-1:0] rdd  [2];
  logic [DW-1:0] dbgd [2];

  phased_pdp_sram #(.AW(AW), .DW(DW), .WR_ODD(1'b0), .TRANSPARENT(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .wr_slot(slot[0]), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rdd[0]),
    .dbg_sel(dbg_sel), .dbg_addr(dbg_addr), .dbg_data(dbgd[0]));

  phased_pdp_sram #(.AW(AW), .DW(DW), .WR_ODD(1'b1), .TRANSPARENT(1'b0)) dut_nt (
    .clk(clk), .rst_n(rst_n), .wr_slot(slot[1]), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rdd[1]),
    .dbg_sel(dbg_sel), .dbg_addr(dbg_addr), .dbg_data(dbgd[1]));

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  logic [DW-1:0] ref_p [2][DEPTH];
  logic [DW-1:0] ref_m [2][DEPTH];
  bit            pend  [2];
  logic [AW-1:0] pa    [2];
  logic [DW-1:0] pd    [2];
  logic [DW-1:0] exp_rd [2];
  string         exp_tag [2];
  bit            odd  [2] = '{1'b0, 1'b1};
  bit            trans[2] = '{1'b1, 1'b0};

  task automatic chk(string req, int unit, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s unit %0d: actual=%h expected=%h", req, unit, act, exp);
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    rd_addr = '0; dbg_addr = '0; dbg_sel = 1'b0;
    for (int t = 0; t < 2; t++) pend[t] = 0;
    repeat (3) @(negedge clk);
    // R1 reset state: phase 0 is the write slot only for WR_ODD=0
    chk("R1", 0, DW'(slot[0]), DW'(1));
    chk("R1", 1, DW'(slot[1]), DW'(0));
    rst_n = 1'b1;
    for (int cyc = 0; cyc < NCYC; cyc++) begin
      if (cyc < INIT) begin
        wr_en   = 1'b1;
        wr_addr = AW'(cyc >> 1);
      end else begin
        wr_en   = ($urandom % 4) != 0;
        wr_addr = AW'($urandom);
      end
      wr_data  = DW'($urandom);
      rd_addr  = (($urandom % 10) < 4) ? wr_addr : AW'($urandom);
      dbg_addr = (($urandom % 2) == 0) ? wr_addr : AW'($urandom);
      dbg_sel  = 1'($urandom);
      #1;
      for (int t = 0; t < 2; t++) begin
        // R1 alternation
        chk("R1", t, DW'(slot[t]), DW'((cyc % 2) == int'(odd[t])));
        if (cyc > INIT + 1) begin
          chk(exp_tag[t], t, rdd[t], exp_rd[t]);
          // R8 debug view; mirror lag is R7
          chk(dbg_sel ? "R8 R7" : "R8", t, dbgd[t],
              dbg_sel ? ref_m[t][dbg_addr] : ref_p[t][dbg_addr]);
        end
      end
      for (int t = 0; t < 2; t++) begin
        bit acc;
        acc = wr_en && ((cyc % 2) == int'(odd[t]));
        if (acc && rd_addr == wr_addr) begin
          exp_rd[t]  = trans[t] ? wr_data : ref_p[t][rd_addr];
          exp_tag[t] = trans[t] ? "R6" : "R5";
        end else begin
          exp_rd[t]  = ref_p[t][rd_addr];
          exp_tag[t] = (wr_en && !acc && rd_addr == wr_addr) ? "R3" : "R2 R4";
        end
        if (pend[t]) ref_m[t][pa[t]] = pd[t];
        pend[t] = acc;
        pa[t] = wr_addr;
        pd[t] = wr_data;
        if (acc) ref_p[t][wr_addr] = wr_data;
      end
      @(negedge clk);
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule